// File: doc/BRIEF.md
# Static Memory Write-Cycle Sequencer

This block turns one host write request into a complete write access on an external asynchronous static memory. It counts in system clock cycles. A host offers an address, a data word and per-byte enables on a valid/ready port. Once the block takes the request, it holds address and data on the memory buses for the whole access. It drives an active-low write strobe and an active-low chip select. Each of the two has its own delay from the start of the access and its own low-time, and both sit inside one total access length.

Both strobes have separate timing settings because memories differ in which edge latches data and how long the select must enclose the write pulse. After a strobe rises, the access continues until the total length is reached; those remaining clocks form that strobe's hold time, with address and data still valid. A byte-lane option moves the write pulse from the single strobe onto one line per byte, and only the enabled bytes are pulsed. All timing settings are static input ports that the surrounding chip ties or drives from its own configuration.

Top module: `sram_write_timer`

## Requirements
- R1: `reqReady` is high exactly when no access is in progress. A request is taken on a rising edge where `reqValid` and `reqReady` are both high. The address and data taken then appear on `memAddr` and `memData` in the first cycle of the access and stay unchanged until the access ends.
- R2: Cycles of an access are numbered from 0, where cycle 0 is the first clock period after the accepting edge. The write strobe is low in cycle k exactly when `cfgWeSetup` <= k < `cfgWeSetup` + P, where P is the effective write pulse count.
- R3: The chip select is low in cycle k exactly when `cfgCsSetup` <= k < `cfgCsSetup` + Q, where Q is the effective select pulse count. This window does not depend on the write-strobe settings.
- R4: A pulse count of 0 is used as 1. Otherwise the effective pulse count equals the programmed value, so every access shows at least one low clock on each strobe.
- R5: The access lasts L cycles, where L is the largest of `cfgCycle`, `cfgWeSetup` + P, `cfgCsSetup` + Q and 1. Each strobe stays high from the end of its window until cycle L-1 (its hold time).
- R6: `done` is high for exactly one clock, during cycle L-1. `reqReady` returns high in the clock after that.
- R7: When `cfgByteMode` is 0, `memWeN` carries the write pulse and all bits of `memByteWeN` stay high. When it is 1, `memWeN` stays high and bit i of `memByteWeN` follows the write window only if byte enable bit i (data bits 8i+7 to 8i) was set in the request; the other bits stay high for the whole access.
- R8: After reset, and whenever the block is idle, `memWeN`, `memCsN` and all `memByteWeN` bits are high and `done` is low.
- R9: A request offered while an access is in progress has no effect. The address bus keeps the current access's address, and no further access follows unless the request is still offered once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWeSetup | input | CNT_W | Clocks from start of access to write strobe falling |
| cfgWePulse | input | CNT_W | Write strobe low time in clocks (0 acts as 1) |
| cfgCsSetup | input | CNT_W | Clocks from start of access to chip select falling |
| cfgCsPulse | input | CNT_W | Chip select low time in clocks (0 acts as 1) |
| cfgCycle | input | CNT_W+1 | Requested total access length in clocks |
| cfgByteMode | input | 1 | 1: pulse per-byte write lines, 0: pulse the single write strobe |
| reqValid | input | 1 | Host offers a write |
| reqReady | output | 1 | Block idle, request will be taken |
| reqAddr | input | ADDR_W | Write address |
| reqData | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables |
| done | output | 1 | One-clock pulse on the last cycle of an access |
| memAddr | output | ADDR_W | Memory address bus |
| memData | output | DATA_W | Memory data bus |
| memWeN | output | 1 | Write strobe, active low |
| memByteWeN | output | DATA_W/8 | Per-byte write strobes, active low |
| memCsN | output | 1 | Chip select, active low |

## Verification
The bench sweeps every combination of setup and pulse counts from 0 to 3 for both strobes against every requested total length from 0 to 7. This separates cases where the requested length governs from cases where one strobe's window forces a longer access. It also separates zero from nonzero pulse counts, and select windows that enclose, lead or trail the write window. Every byte-enable pattern is then run in byte mode at several write timings, which shows that each line is gated by its own enable. A few accesses carry a second request offered mid-access with a different address, which shows it neither disturbs the bus nor starts an access.

// File: rtl/sram_write_timer_pkg.sv
package sram_write_timer_pkg;

  // Strobes passed from the control to the datapath, valid for the next cycle.
  typedef struct packed {
    logic load;   // request taken on this edge
    logic weOn;   // write window active in the next cycle
    logic csOn;   // select window active in the next cycle
    logic done;   // next cycle is the last of the access
  } wrStrobes_t;

endpackage

// File: rtl/sram_write_window.sv
// Decides whether a strobe is inside its low window at a given cycle index,
// and reports where its window ends so the access length can be stretched.
module sram_write_window #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  input  logic [CNT_W:0]   index,
  output logic             active,
  output logic [CNT_W:0]   spanEnd
);
  localparam int SW = CNT_W + 1;

  logic [SW-1:0] pulseEff;
  logic [SW-1:0] startIdx;

  always_comb begin
    pulseEff = (pulse == '0) ? SW'(1) : {1'b0, pulse};
    startIdx = {1'b0, setup};
    spanEnd  = startIdx + pulseEff;
    active   = (index >= startIdx) && (index < spanEnd);
  end
endmodule

// File: rtl/sram_write_ctl.sv
// Access counter and window decoding.
module sram_write_ctl
  import sram_write_timer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgWeSetup,
  input  logic [CNT_W-1:0] cfgWePulse,
  input  logic [CNT_W-1:0] cfgCsSetup,
  input  logic [CNT_W-1:0] cfgCsPulse,
  input  logic [CNT_W:0]   cfgCycle,
  input  logic             reqValid,
  output logic             busy,
  output wrStrobes_t       strb
);
  localparam int SW     = CNT_W + 1;
  localparam int N_STRB = 2;   // 0: write strobe, 1: chip select

  logic [SW-1:0] cnt, cntNext;
  logic          busyNext;
  logic [SW-1:0] lenEff;
  logic [SW-1:0] lastIdx;

  logic [CNT_W-1:0] winSetup [N_STRB];
  logic [CNT_W-1:0] winPulse [N_STRB];
  logic [SW-1:0]    winEnd   [N_STRB];
  logic [N_STRB-1:0] winOn;

  always_comb begin
    winSetup[0] = cfgWeSetup;
    winPulse[0] = cfgWePulse;
    winSetup[1] = cfgCsSetup;
    winPulse[1] = cfgCsPulse;
  end

  for (genvar g = 0; g < N_STRB; g++) begin : g_win
    sram_write_window #(.CNT_W(CNT_W)) u_win (
      .setup  (winSetup[g]),
      .pulse  (winPulse[g]),
      .index  (cntNext),
      .active (winOn[g]),
      .spanEnd(winEnd[g])
    );
  end

  // Total length: the requested value, stretched to fit both windows.
  always_comb begin
    lenEff = (cfgCycle == '0) ? SW'(1) : cfgCycle;
    for (int i = 0; i < N_STRB; i++) begin
      if (winEnd[i] > lenEff) lenEff = winEnd[i];
    end
    lastIdx = lenEff - SW'(1);
  end

  always_comb begin
    strb.load = reqValid && !busy;
    cntNext   = cnt;
    busyNext  = busy;
    if (strb.load) begin
      cntNext  = '0;
      busyNext = 1'b1;
    end else if (busy) begin
      if (cnt == lastIdx) begin
        cntNext  = '0;
        busyNext = 1'b0;
      end else begin
        cntNext = cnt + SW'(1);
      end
    end
    strb.weOn = busyNext && winOn[0];
    strb.csOn = busyNext && winOn[1];
    strb.done = busyNext && (cntNext == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt  <= cntNext;
      busy <= busyNext;
    end
  end
endmodule

// File: rtl/sram_write_dp.sv
// Captures the request and registers every memory-side output.
module sram_write_dp
  import sram_write_timer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobes_t          strb,
  input  logic                cfgByteMode,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memByteWeN,
  output logic                memCsN,
  output logic                done
);
  localparam int NBYTE = DATA_W / 8;

  logic [NBYTE-1:0] beQ;
  logic [NBYTE-1:0] beSel;
  logic [NBYTE-1:0] byteOn;

  always_comb begin
    beSel = strb.load ? reqBe : beQ;
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign byteOn[b] = cfgByteMode && strb.weOn && beSel[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
      beQ     <= '0;
    end else if (strb.load) begin
      memAddr <= reqAddr;
      memData <= reqData;
      beQ     <= reqBe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWeN     <= 1'b1;
      memByteWeN <= '1;
      memCsN     <= 1'b1;
      done       <= 1'b0;
    end else begin
      memWeN     <= !(strb.weOn && !cfgByteMode);
      memByteWeN <= ~byteOn;
      memCsN     <= !strb.csOn;
      done       <= strb.done;
    end
  end
endmodule

// File: rtl/sram_write_timer.sv
module sram_write_timer
  import sram_write_timer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cfgWeSetup,
  input  logic [CNT_W-1:0]    cfgWePulse,
  input  logic [CNT_W-1:0]    cfgCsSetup,
  input  logic [CNT_W-1:0]    cfgCsPulse,
  input  logic [CNT_W:0]      cfgCycle,
  input  logic                cfgByteMode,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                done,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memByteWeN,
  output logic                memCsN
);
  wrStrobes_t strb;
  logic       busy;

  sram_write_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWeSetup(cfgWeSetup),
    .cfgWePulse(cfgWePulse),
    .cfgCsSetup(cfgCsSetup),
    .cfgCsPulse(cfgCsPulse),
    .cfgCycle  (cfgCycle),
    .reqValid  (reqValid),
    .busy      (busy),
    .strb      (strb)
  );

  sram_write_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgByteMode(cfgByteMode),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqBe      (reqBe),
    .memAddr    (memAddr),
    .memData    (memData),
    .memWeN     (memWeN),
    .memByteWeN (memByteWeN),
    .memCsN     (memCsN),
    .done       (done)
  );

  assign reqReady = !busy;
endmodule

// File: rtl/sram_write_timer_chk.sv
module sram_write_timer_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgByteMode,
  input logic                reqValid,
  input logic                reqReady,
  input logic                done,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memWeN,
  input logic [DATA_W/8-1:0] memByteWeN,
  input logic                memCsN
);
  // R1: taking a request makes the block busy
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R1, R9: the address bus holds still through an access
  a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

  // R6: done is a single-clock pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done only appears inside an access
  a_r6_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqReady);

  // R8: all strobes inactive while idle
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memWeN && memCsN && (&memByteWeN)));

  // R7: the single strobe stays high in byte-lane mode
  a_r7_byte_mode_we_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByteMode && $past(cfgByteMode)) |-> memWeN);
endmodule

bind sram_write_timer sram_write_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgByteMode(cfgByteMode),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .done       (done),
  .memAddr    (memAddr),
  .memWeN     (memWeN),
  .memByteWeN (memByteWeN),
  .memCsN     (memCsN)
);

// File: tb/sram_write_timer_tb.sv
`timescale 1ns/1ps
module sram_write_timer_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 3;
  localparam int NBYTE  = DATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] cfgWeSetup = '0, cfgWePulse = '0, cfgCsSetup = '0, cfgCsPulse = '0;
  logic [CNT_W:0]   cfgCycle = '0;
  logic             cfgByteMode = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [NBYTE-1:0]  reqBe = '0;
  logic              done;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              memWeN;
  logic [NBYTE-1:0]  memByteWeN;
  logic              memCsN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_write_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgWeSetup(cfgWeSetup), .cfgWePulse(cfgWePulse),
    .cfgCsSetup(cfgCsSetup), .cfgCsPulse(cfgCsPulse),
    .cfgCycle(cfgCycle), .cfgByteMode(cfgByteMode),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .done(done), .memAddr(memAddr), .memData(memData),
    .memWeN(memWeN), .memByteWeN(memByteWeN), .memCsN(memCsN)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Packed view: {weN, byteWeN[3:0], csN, done, ready}
  function automatic logic [7:0] outVec();
    return {memWeN, memByteWeN, memCsN, done, reqReady};
  endfunction

  task automatic runOne(input int ws, input int wp, input int cs, input int cp,
                        input int cyc, input bit mode, input logic [NBYTE-1:0] be,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input bit intrude);
    int wpe, cpe, len;
    logic [7:0] expV;
    bit weLow, csLow;
    wpe = (wp == 0) ? 1 : wp;
    cpe = (cp == 0) ? 1 : cp;
    len = (cyc == 0) ? 1 : cyc;
    if (ws + wpe > len) len = ws + wpe;
    if (cs + cpe > len) len = cs + cpe;

    cfgWeSetup = CNT_W'(ws); cfgWePulse = CNT_W'(wp);
    cfgCsSetup = CNT_W'(cs); cfgCsPulse = CNT_W'(cp);
    cfgCycle = (CNT_W+1)'(cyc); cfgByteMode = mode;
    check(reqReady === 1'b1, "R1 ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < len; k++) begin
      weLow = (k >= ws) && (k < ws + wpe);
      csLow = (k >= cs) && (k < cs + cpe);
      expV[7]   = mode ? 1'b1 : !weLow;
      for (int b = 0; b < NBYTE; b++) expV[3+b] = !(mode && weLow && be[b]);
      expV[2]   = !csLow;
      expV[1]   = (k == len - 1);
      expV[0]   = 1'b0;
      check(outVec() === expV, "R2 R3 R4 R5 R6 R7 strobe waveform", 64'(outVec()), 64'(expV));
      check({memAddr, memData} === {a, d}, "R1 R9 address and data held",
            64'({memAddr, memData}), 64'({a, d}));
      if (intrude && k == 0) begin
        reqValid = 1'b1; reqAddr = ~a; reqData = ~d;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(outVec() === 8'b1111_1101, "R6 R8 idle after access", 64'(outVec()), 64'hFD);
    if (intrude) begin
      @(negedge clk);
      check(outVec() === 8'b1111_1101 && memAddr === a, "R9 no access from ignored request",
            64'({outVec(), memAddr}), 64'({8'hFD, a}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outVec() === 8'b1111_1101, "R8 reset state", 64'(outVec()), 64'hFD);
    rstN = 1'b1;
    @(negedge clk);
    check(outVec() === 8'b1111_1101, "R8 idle after reset", 64'(outVec()), 64'hFD);

    // Single-strobe mode: full timing sweep (R2 R3 R4 R5)
    for (int ws = 0; ws < 4; ws++)
      for (int wp = 0; wp < 4; wp++)
        for (int cs = 0; cs < 4; cs++)
          for (int cp = 0; cp < 4; cp++)
            for (int cyc = 0; cyc < 8; cyc++)
              runOne(ws, wp, cs, cp, cyc, 1'b0, 4'hF,
                     ADDR_W'(ws * 64 + wp * 16 + cs * 4 + cp),
                     DATA_W'(32'hA5000000 + cyc * 4096 + ws * 256 + cp), 1'b0);

    // Byte-lane mode: every enable pattern (R7)
    for (int be = 0; be < 16; be++)
      for (int ws = 0; ws < 4; ws++)
        for (int wp = 0; wp < 4; wp++)
          runOne(ws, wp, 0, 3, be % 8, 1'b1, 4'(be),
                 ADDR_W'(be * 16 + ws), DATA_W'(32'h5A5A0000 + be), 1'b0);

    // Requests during an access are ignored (R9)
    runOne(1, 2, 0, 4, 6, 1'b0, 4'hF, 8'h3C, 32'h1234_5678, 1'b1);
    runOne(0, 0, 0, 0, 0, 1'b0, 4'hF, 8'hC3, 32'h8765_4321, 1'b1);
    runOne(2, 1, 1, 3, 0, 1'b1, 4'h5, 8'h81, 32'hDEAD_BEEF, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule